// File: doc/BRIEF.md
# Pipelined Precise Exception Controller

This block sits beside the hazard logic of a five-stage integer pipeline and turns synchronous faults into precise traps. Two faults are recognised: an undefined opcode flagged by the decode stage, and signed two's-complement overflow of an add in the execute stage. The overflow is computed inside the block from the execute-stage operands. When a fault is taken, the instructions older than the faulting one (those already in the memory and writeback stages) are left to retire. The faulting instruction and every younger one are removed through the same flush paths a mispredicted branch would use, and the faulting instruction's register write is suppressed.

On the trap cycle the block asserts a fetch redirect to the fixed handler entry 0x8000_0180. On the following clock edge it loads the faulting instruction's PC into an exception-PC register and a fault code into a cause register. Between traps both registers keep their values, so handler software can read them and return.

If both stages fault in the same cycle, the execute-stage instruction is the older one and wins. The decode-stage fault is dropped, because that instruction is flushed anyway.

Top module: `precise_trap_ctrl`

## Requirements
- R1: A valid add in the execute stage raises an overflow fault only when both operands have the same sign bit and the 32-bit sum has the opposite sign. An unsigned wrap such as 0xFFFF_FFFF + 1 raises nothing.
- R2: An execute-stage fault asserts `flush_exmem`, `flush_idex`, `flush_ifid` and `redirect` in the same cycle.
- R3: A decode-stage fault with no execute-stage fault asserts `flush_ifid`, `flush_idex` and `redirect`, but not `flush_exmem`, so the instruction in execute proceeds.
- R4: When both stages fault in one cycle, the execute-stage fault is taken: `flush_exmem` is high, and EPC and the cause code come from the execute stage.
- R5: `ex_wr_out` equals `ex_wr_in` except in an execute-stage fault cycle, when it is 0.
- R6: On the clock edge that ends a trap cycle, `epc` loads the PC of the faulting instruction.
- R7: The cause code sits in bits 6:2 of `cause`, with the value 10 for an undefined opcode and 12 for overflow. All other bits of `cause` are 0.
- R8: In any cycle without a trap, `epc` and `cause` keep their values.
- R9: `redirect_pc` is 0x8000_0180 whenever `redirect` is high, and 0 otherwise.
- R10: During and right after reset, `epc` and `cause` are 0. With both valid inputs low, all flush and redirect outputs are low.
- R11: A stage whose valid bit is low raises no fault, whatever its fault flag or operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_pc | input | 32 | PC of the decode-stage instruction |
| id_bad_op | input | 1 | Decoder found an undefined opcode |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| ex_add | input | 1 | Execute-stage instruction is a signed add |
| ex_opa | input | 32 | First adder operand in execute |
| ex_opb | input | 32 | Second adder operand in execute |
| ex_wr_in | input | 1 | Register-write enable of the execute-stage instruction |
| flush_ifid | output | 1 | Load a bubble into the IF/ID register |
| flush_idex | output | 1 | Load a bubble into the ID/EX register |
| flush_exmem | output | 1 | Load a bubble into the EX/MEM register |
| redirect | output | 1 | Override the next fetch address |
| redirect_pc | output | 32 | Next fetch address when redirecting |
| ex_wr_out | output | 1 | Register-write enable passed on to EX/MEM |
| epc | output | 32 | Saved PC of the last faulting instruction |
| cause | output | 32 | Saved fault code in bits 6:2 |

## Verification
On every cycle, the assertions check how the flush outputs relate to each other and to the stage valid bits, and that the write enable is blocked whenever the execute stage is flushed. They also check the handler address, the format of the cause register, that EPC is captured from the correct stage, and that both saved registers hold between traps. Precise retirement can only be shown by the bench's small pipeline model: the older adds at 0x40 to 0x48 commit their results, the overflowing add at 0x4C leaves its destination register untouched, its younger instructions never write, and the next fetch is at the handler. Randomised mixes of simultaneous faults and borderline operand signs are compared against bench functions.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 5'd0,
    CODE_BADOP = 5'd10,
    CODE_OVF   = 5'd12
  } trap_code_e;
endpackage

// File: rtl/trap_ovf_detect.sv
// Signed overflow of a + b from the carries into and out of the sign bit.
module trap_ovf_detect #(
  parameter int XLEN = 32
) (
  input  logic            en,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            ovf
);
  logic [XLEN:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < XLEN; i++) begin : g_carry
    assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
  end

  assign ovf = en & (carry[XLEN] ^ carry[XLEN-1]);
endmodule

// File: rtl/trap_arbiter.sv
// Selects the oldest faulting stage; execute outranks decode.
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic            ex_hit,
  input  logic [PCW-1:0]  ex_pc,
  input  logic            id_hit,
  input  logic [PCW-1:0]  id_pc,
  output logic            take,
  output logic            from_ex,
  output logic [PCW-1:0]  sel_pc,
  output trap_code_e      sel_code
);
  always_comb begin
    take     = ex_hit | id_hit;
    from_ex  = ex_hit;
    sel_pc   = '0;
    sel_code = CODE_NONE;
    if (ex_hit) begin
      sel_pc   = ex_pc;
      sel_code = CODE_OVF;
    end else if (id_hit) begin
      sel_pc   = id_pc;
      sel_code = CODE_BADOP;
    end
  end
endmodule

// File: rtl/trap_regs.sv
// Exception-PC and cause registers, loaded only on a taken trap.
module trap_regs
  import trap_pkg::*;
#(
  parameter int PCW      = 32,
  parameter int CAUSE_W  = 32,
  parameter int CODE_LSB = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [PCW-1:0]     pc_in,
  input  trap_code_e         code_in,
  output logic [PCW-1:0]     epc,
  output logic [CAUSE_W-1:0] cause
);
  logic [PCW-1:0]     epc_q, epc_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [CAUSE_W-1:0] cause_new;

  always_comb begin
    cause_new = '0;
    cause_new[CODE_LSB +: CODE_W] = code_in;
  end

  always_comb begin
    epc_d   = epc_q;
    cause_d = cause_q;
    if (take) begin
      epc_d   = pc_in;
      cause_d = cause_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  assign epc   = epc_q;
  assign cause = cause_q;
endmodule

// File: rtl/precise_trap_ctrl.sv
module precise_trap_ctrl
  import trap_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          PCW        = 32,
  parameter int          CAUSE_W    = 32,
  parameter int          CODE_LSB   = 2,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_valid,
  input  logic [PCW-1:0]     id_pc,
  input  logic               id_bad_op,
  input  logic               ex_valid,
  input  logic [PCW-1:0]     ex_pc,
  input  logic               ex_add,
  input  logic [XLEN-1:0]    ex_opa,
  input  logic [XLEN-1:0]    ex_opb,
  input  logic               ex_wr_in,
  output logic               flush_ifid,
  output logic               flush_idex,
  output logic               flush_exmem,
  output logic               redirect,
  output logic [PCW-1:0]     redirect_pc,
  output logic               ex_wr_out,
  output logic [PCW-1:0]     epc,
  output logic [CAUSE_W-1:0] cause
);
  localparam logic [PCW-1:0] VEC = PCW'(HANDLER_PC);

  logic            ex_hit, id_hit, take, from_ex;
  logic [PCW-1:0]  sel_pc;
  trap_code_e      sel_code;

  trap_ovf_detect #(.XLEN(XLEN)) u_ovf (
    .en  (ex_valid & ex_add),
    .a   (ex_opa),
    .b   (ex_opb),
    .ovf (ex_hit)
  );

  assign id_hit = id_valid & id_bad_op;

  trap_arbiter #(.PCW(PCW)) u_arb (
    .ex_hit   (ex_hit),
    .ex_pc    (ex_pc),
    .id_hit   (id_hit),
    .id_pc    (id_pc),
    .take     (take),
    .from_ex  (from_ex),
    .sel_pc   (sel_pc),
    .sel_code (sel_code)
  );

  trap_regs #(.PCW(PCW), .CAUSE_W(CAUSE_W), .CODE_LSB(CODE_LSB)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .pc_in   (sel_pc),
    .code_in (sel_code),
    .epc     (epc),
    .cause   (cause)
  );

  assign flush_exmem = from_ex;
  assign flush_idex  = take;
  assign flush_ifid  = take;
  assign redirect    = take;
  assign redirect_pc = take ? VEC : '0;
  assign ex_wr_out   = ex_wr_in & ~from_ex;
endmodule

// File: rtl/precise_trap_ctrl_chk.sv
module precise_trap_ctrl_chk #(
  parameter int          XLEN       = 32,
  parameter int          PCW        = 32,
  parameter int          CAUSE_W    = 32,
  parameter int          CODE_LSB   = 2,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0180
) (
  input logic               clk,
  input logic               rst_n,
  input logic               id_valid,
  input logic [PCW-1:0]     id_pc,
  input logic               id_bad_op,
  input logic               ex_valid,
  input logic [PCW-1:0]     ex_pc,
  input logic               ex_add,
  input logic [XLEN-1:0]    ex_opa,
  input logic [XLEN-1:0]    ex_opb,
  input logic               ex_wr_in,
  input logic               flush_ifid,
  input logic               flush_idex,
  input logic               flush_exmem,
  input logic               redirect,
  input logic [PCW-1:0]     redirect_pc,
  input logic               ex_wr_out,
  input logic [PCW-1:0]     epc,
  input logic [CAUSE_W-1:0] cause
);
  localparam logic [CAUSE_W-1:0] FIELD = CAUSE_W'(5'h1f) << CODE_LSB;
  localparam logic [CAUSE_W-1:0] C_BAD = CAUSE_W'(5'd10) << CODE_LSB;
  localparam logic [CAUSE_W-1:0] C_OVF = CAUSE_W'(5'd12) << CODE_LSB;

  logic [XLEN-1:0] sum_chk;
  logic            ovf_chk;
  assign sum_chk = ex_opa + ex_opb;
  assign ovf_chk = (ex_opa[XLEN-1] == ex_opb[XLEN-1]) && (sum_chk[XLEN-1] != ex_opa[XLEN-1]);

  p_ovf_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_add && ovf_chk) |-> flush_exmem);
  p_ovf_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exmem |-> (ex_add && ovf_chk));
  p_flush_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exmem |-> (flush_idex && flush_ifid && redirect));
  p_id_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !flush_exmem) |-> (id_valid && id_bad_op && flush_ifid && flush_idex));
  p_ex_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exmem |=> (cause == C_OVF));
  p_write_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exmem |-> !ex_wr_out);
  p_write_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_exmem |-> (ex_wr_out == ex_wr_in));
  p_epc_ex_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exmem |=> (epc == $past(ex_pc)));
  p_epc_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !flush_exmem) |=> (epc == $past(id_pc) && cause == C_BAD));
  p_cause_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause & ~FIELD) == '0) && (cause == '0 || cause == C_BAD || cause == C_OVF));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> ($stable(epc) && $stable(cause)));
  p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_pc == PCW'(HANDLER_PC)));
  p_no_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> (redirect_pc == '0));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_valid && !id_valid) |-> !(redirect || flush_ifid || flush_idex || flush_exmem));
endmodule

bind precise_trap_ctrl precise_trap_ctrl_chk #(
  .XLEN(XLEN), .PCW(PCW), .CAUSE_W(CAUSE_W), .CODE_LSB(CODE_LSB), .HANDLER_PC(HANDLER_PC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_pc(id_pc), .id_bad_op(id_bad_op),
  .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_add(ex_add), .ex_opa(ex_opa), .ex_opb(ex_opb),
  .ex_wr_in(ex_wr_in), .flush_ifid(flush_ifid), .flush_idex(flush_idex),
  .flush_exmem(flush_exmem), .redirect(redirect), .redirect_pc(redirect_pc),
  .ex_wr_out(ex_wr_out), .epc(epc), .cause(cause)
);

// File: tb/test_precise_trap_ctrl.sv
module test_precise_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_valid, id_bad_op, ex_valid, ex_add, ex_wr_in;
  logic [31:0] id_pc, ex_pc, ex_opa, ex_opb;
  logic        flush_ifid, flush_idex, flush_exmem, redirect, ex_wr_out;
  logic [31:0] redirect_pc, epc, cause;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  precise_trap_ctrl i_precise_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_pc(id_pc), .id_bad_op(id_bad_op),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_add(ex_add), .ex_opa(ex_opa), .ex_opb(ex_opb),
    .ex_wr_in(ex_wr_in), .flush_ifid(flush_ifid), .flush_idex(flush_idex),
    .flush_exmem(flush_exmem), .redirect(redirect), .redirect_pc(redirect_pc),
    .ex_wr_out(ex_wr_out), .epc(epc), .cause(cause)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ovf_of(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s;
    s = a + b;
    return (a[31] == b[31]) && (s[31] != a[31]);
  endfunction

  // expected saved state
  logic [31:0] m_epc, m_cause;

  task automatic drive(input bit iv, input logic [31:0] ip, input bit bad,
                       input bit ev, input logic [31:0] ep, input bit ad,
                       input logic [31:0] a, input logic [31:0] b, input bit wr);
    id_valid = iv; id_pc = ip; id_bad_op = bad;
    ex_valid = ev; ex_pc = ep; ex_add = ad; ex_opa = a; ex_opb = b; ex_wr_in = wr;
  endtask

  // one cycle of port-level stimulus with full expectation
  task automatic step(input string tag);
    bit exh, idh;
    @(negedge clk);
    #1;
    exh = ex_valid && ex_add && ovf_of(ex_opa, ex_opb);
    idh = id_valid && id_bad_op;
    check({tag, " R1/R2 flush_exmem"}, {31'd0, flush_exmem}, {31'd0, exh});
    check({tag, " R3 flush_idex"}, {31'd0, flush_idex}, {31'd0, exh | idh});
    check({tag, " R3 flush_ifid"}, {31'd0, flush_ifid}, {31'd0, exh | idh});
    check({tag, " R9 redirect_pc"}, redirect_pc, (exh | idh) ? 32'h8000_0180 : 32'h0);
    check({tag, " R5 ex_wr_out"}, {31'd0, ex_wr_out}, {31'd0, ex_wr_in & ~exh});
    if (exh) begin m_epc = ex_pc; m_cause = 32'd12 << 2; end
    else if (idh) begin m_epc = id_pc; m_cause = 32'd10 << 2; end
    @(posedge clk);
    #1;
    check({tag, " R4/R6/R8 epc"}, epc, m_epc);
    check({tag, " R7/R8 cause"}, cause, m_cause);
  endtask

  // small pipeline model for precise-retirement scenario
  logic [31:0] regs [32];
  int          p_dst [6];
  logic [31:0] p_a   [6];
  logic [31:0] p_b   [6];

  initial begin
    int if_i, id_i, ex_i, mem_i, wb_i, nf;
    bit mem_wr, wb_wr, stop, f_ie, f_ii, f_em, rd, wro;
    logic [31:0] mem_v, wb_v, rpc, hpc, epc_seen, cause_seen;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));

    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_epc = 0; m_cause = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset epc", epc, 0);
    check("R10 reset cause", cause, 0);
    check("R10 reset redirect", {31'd0, redirect}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed cases
    drive(0, 32'h10, 1, 1, 32'h20, 1, 32'h7fff_ffff, 32'h1, 1); step("R11 id invalid, ex pos ovf");
    drive(1, 32'h30, 1, 0, 32'h34, 1, 32'h7fff_ffff, 32'h1, 1); step("R3 id bad only");
    drive(1, 32'h40, 1, 1, 32'h44, 1, 32'h8000_0000, 32'hffff_ffff, 1); step("R4 both fault");
    drive(0, 0, 0, 1, 32'h50, 1, 32'hffff_ffff, 32'h1, 1); step("R1 unsigned wrap");
    drive(0, 0, 0, 1, 32'h54, 0, 32'h7fff_ffff, 32'h7fff_ffff, 1); step("R1 not add");
    drive(0, 0, 0, 0, 32'h58, 1, 32'h8000_0000, 32'h8000_0000, 1); step("R11 ex invalid");
    drive(0, 0, 0, 1, 32'h5c, 1, 32'h7fff_fffe, 32'h1, 1); step("R1 edge no ovf");
    drive(1, 32'h60, 0, 1, 32'h64, 1, 32'h1, 32'h2, 0); step("R8 quiet hold");

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      int sel;
      sel = $urandom_range(0, 3);
      case (sel)
        0: begin a = 32'h7000_0000 | $urandom_range(0, 32'h0fff_ffff);
                 b = 32'h1000_0000 | $urandom_range(0, 32'h0fff_ffff); end
        1: begin a = 32'h8000_0000 | $urandom_range(0, 32'h0fff_ffff);
                 b = 32'h8000_0000 | $urandom_range(0, 32'h7fff_ffff); end
        default: begin a = $urandom; b = $urandom; end
      endcase
      drive($urandom_range(0, 1), $urandom & 32'hffff_fffc, $urandom_range(0, 3) == 0,
            $urandom_range(0, 1), $urandom & 32'hffff_fffc, $urandom_range(0, 3) != 0,
            a, b, $urandom_range(0, 1));
      step("rand");
    end

    // precise retirement: overflowing add at 0x4C after three older adds
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_epc = 0; m_cause = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 32; r++) regs[r] = 32'hA000 + r;
    p_dst[0] = 11; p_a[0] = 5;            p_b[0] = 3;
    p_dst[1] = 12; p_a[1] = 100;          p_b[1] = 32'hffff_ffff;
    p_dst[2] = 13; p_a[2] = 7;            p_b[2] = 7;
    p_dst[3] = 1;  p_a[3] = 32'h7fff_ffff; p_b[3] = 1;
    p_dst[4] = 15; p_a[4] = 1;            p_b[4] = 1;
    p_dst[5] = 16; p_a[5] = 2;            p_b[5] = 2;
    if_i = 0; nf = 1; id_i = -1; ex_i = -1; mem_i = -1; wb_i = -1;
    mem_wr = 0; wb_wr = 0; mem_v = 0; wb_v = 0; stop = 0; hpc = 0;
    epc_seen = 0; cause_seen = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      id_valid = (id_i >= 0); id_pc = (id_i >= 0) ? 32'h40 + 4 * id_i : 0; id_bad_op = 0;
      ex_valid = (ex_i >= 0); ex_pc = (ex_i >= 0) ? 32'h40 + 4 * ex_i : 0; ex_add = 1;
      ex_opa = (ex_i >= 0) ? p_a[ex_i] : 0; ex_opb = (ex_i >= 0) ? p_b[ex_i] : 0;
      ex_wr_in = (ex_i >= 0);
      #1;
      f_ie = flush_idex; f_ii = flush_ifid; f_em = flush_exmem; rd = redirect;
      rpc = redirect_pc; wro = ex_wr_out;
      @(posedge clk);
      #1;
      if (rd) begin epc_seen = epc; cause_seen = cause; end
      if (wb_i >= 0 && wb_wr) regs[p_dst[wb_i]] = wb_v;
      wb_i = mem_i; wb_wr = mem_wr; wb_v = mem_v;
      if (f_em || ex_i < 0) begin mem_i = -1; mem_wr = 0; end
      else begin mem_i = ex_i; mem_wr = wro; mem_v = p_a[ex_i] + p_b[ex_i]; end
      ex_i = f_ie ? -1 : id_i;
      id_i = f_ii ? -1 : if_i;
      if (rd && !stop) begin stop = 1; hpc = rpc; if_i = -1; end
      else if (!stop && nf < 6) begin if_i = nf; nf++; end
      else if_i = -1;
    end
    check("R6 epc of add at 0x4C", epc_seen, 32'h4c);
    check("R7 overflow cause", cause_seen, 32'd12 << 2);
    check("R9 next fetch at handler", hpc, 32'h8000_0180);
    check("R2 older r11 committed", regs[11], 32'd8);
    check("R2 older r12 committed", regs[12], 32'd99);
    check("R2 older r13 committed", regs[13], 32'd14);
    check("R5 faulting dest unchanged", regs[1], 32'hA001);
    check("R2 younger r15 squashed", regs[15], 32'hA00F);
    check("R2 younger r16 squashed", regs[16], 32'hA010);
    check("R8 epc held after trap", epc, 32'h4c);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule